// File: doc/BRIEF.md
# Boost Converter Start-Up Sequencer

This block brings up a battery-fed boost converter that supplies a bus. A start request steps it through three states. First it precharges the output from a linear current source. Next it switches in soft-start with a reduced current limit. Last it runs in closed loop at the full limit. Each state is watched by a time window counted in microsecond ticks. Every window comes from one shared down-counter, which is reloaded each time a state is entered.

Inside the regulated state, several conditions stop the converter and record a three-bit cause: over-temperature, bus overvoltage, a sagging battery and a current limit that lasts too long. A stall in precharge or soft-start also counts as a fault. On any fault the block turns the power stage off and emits a one-cycle status pulse. It also emits a one-cycle request to clear the host's boost command. What happens next depends on who asked for boost:
- A request from the external pin is retried automatically, first after one interval and then at a slightly shorter repeat interval.
- A request from the host waits until the host removes its command and issues it again.

The pin's active level is selectable. A pin request overrides the host's high-impedance request.

Top module: `boost_start_seq`

## Requirements
- R1: A start request moves the sequencer from idle to precharge (`precharge_en`=1 one cycle later) only while `bat_above_uv`=1. While `bat_above_uv`=0 it stays idle with all power outputs low. A start request is either `host_boost_en`=1 with `hiz_req`=0, or an active pin request (see R11).
- R2: Precharge lasts at most LIN_US ticks. If `vout_near_bat` never rises, `precharge_en` stays high for LIN_US+1 cycles when a tick arrives every cycle. The block then faults with `fault_code`=3'b010.
- R3: `vout_near_bat`=1 during precharge moves to soft-start stage one: `switch_en`=1, `ilim_full`=0, `precharge_en`=0.
- R4: `vout_at_95`=1 in either soft-start stage moves to regulation: `switch_en`=1, `ilim_full`=1.
- R5: Stage one lasts SS1_US ticks (SS1_US+1 cycles at one tick per cycle), then the full limit is selected. Stage two lasts SS2_US more ticks (SS2_US+1 cycles), then the block faults with 3'b010.
- R6: In regulation, `ilim_active` held for more than CL_US consecutive ticks gives fault 3'b010, after `switch_en` has stayed high for CL_US+1 cycles. Holding it for exactly CL_US ticks gives no fault.
- R7: Regulation faults use the following codes and priority:
  - thermal (3'b101) beats overvoltage (3'b001);
  - overvoltage beats low battery (`bat_above_uv`=0, 3'b011);
  - low battery beats the current-limit fault.
- R8: On a fault, `stat_pulse` and `boost_cmd_clr` are high for exactly one cycle, the first cycle in the fault state. All power outputs are low. `fault_code` holds its value.
- R9: With a pin request active, the first retry re-enters precharge RETRY1_US ticks after the fault. Later retries wait RETRY2_US ticks. The fault state lasts RETRY1_US+1 and RETRY2_US+1 cycles at one tick per cycle.
- R10: With a host request, no retry happens. After the command is removed and reapplied, precharge restarts and `fault_code` reads 3'b000.
- R11: The pin is active when `otg_pin` equals `pin_active_high` and `pin_boost_allow`=1. An active pin starts boost even with `hiz_req`=1.
- R12: When the start request goes away, `precharge_en`, `switch_en`, `ilim_full`, `stat_pulse` and `boost_cmd_clr` drop in the same cycle, and the sequencer returns to idle.
- R13: Windows advance only on `us_tick`. With `us_tick`=0 no window expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_boost_en | input | 1 | Host boost command |
| hiz_req | input | 1 | Host high-impedance request |
| pin_boost_allow | input | 1 | Lets the external pin start boost |
| pin_active_high | input | 1 | 1: pin active high, 0: active low |
| otg_pin | input | 1 | External boost request pin level |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| vout_near_bat | input | 1 | Output within 400 mV of battery |
| vout_at_95 | input | 1 | Output at 95% of setpoint |
| bat_above_uv | input | 1 | Battery above boost undervoltage level |
| bus_ovp | input | 1 | Bus overvoltage |
| ilim_active | input | 1 | Current limit active |
| therm_shdn | input | 1 | Thermal shutdown |
| precharge_en | output | 1 | Linear precharge source enable |
| switch_en | output | 1 | Power stage switching enable |
| ilim_full | output | 1 | 1: full current limit, 0: half |
| fault_code | output | 3 | Latched fault cause |
| stat_pulse | output | 1 | One-cycle status pulse on fault |
| boost_cmd_clr | output | 1 | One-cycle request to clear host boost command |

## Verification
A wrong state register shows up at the power outputs in the very next cycle:
- precharge and switching would overlap;
- the current-limit select would be high without switching;
- a fault state would still drive the stage.

A mis-loaded or mis-counted window shifts the cycle at which an output falls by a measurable number of cycles. The bench measures each window's length exactly against the tick count. A wrong fault priority or retry interval appears directly in `fault_code` or in the off-time between attempts.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LIN,
    ST_SS1,
    ST_SS2,
    ST_RUN,
    ST_FAULT
  } seq_state_t;

  localparam logic [2:0] FC_NONE    = 3'b000;
  localparam logic [2:0] FC_OVP     = 3'b001;
  localparam logic [2:0] FC_TIMEOUT = 3'b010;
  localparam logic [2:0] FC_UVLO    = 3'b011;
  localparam logic [2:0] FC_THERM   = 3'b101;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Pin request decode: active level chosen by pol
  function automatic logic pin_asserted(input logic pin, input logic pol);
    return pin == pol;
  endfunction

  // Fault selection in regulation, highest priority first
  function automatic logic [2:0] run_fault(input logic therm, input logic ovp,
                                           input logic bat_ok, input logic cl_exp);
    if (therm)        return FC_THERM;
    else if (ovp)     return FC_OVP;
    else if (!bat_ok) return FC_UVLO;
    else if (cl_exp)  return FC_TIMEOUT;
    else              return FC_NONE;
  endfunction

endpackage

// File: rtl/boost_seq_enable.sv
module boost_seq_enable (
  input  logic host_boost_en,
  input  logic hiz_req,
  input  logic pin_boost_allow,
  input  logic pin_active_high,
  input  logic otg_pin,
  output logic run_en,
  output logic pin_req
);
  import boost_seq_pkg::*;

  logic host_req;

  assign pin_req  = pin_boost_allow && pin_asserted(otg_pin, pin_active_high);
  assign host_req = host_boost_en && !hiz_req;
  assign run_en   = host_req || pin_req;

endmodule

// File: rtl/boost_seq_timer.sv
module boost_seq_timer #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt <= $past(cnt)); // R13
  AST_CNT_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt)); // R13

endmodule

// File: rtl/boost_seq_fsm.sv
module boost_seq_fsm #(
  parameter int unsigned LIN_T    = 560,
  parameter int unsigned SS1_T    = 128,
  parameter int unsigned SS2_T    = 384,
  parameter int unsigned CL_T     = 50,
  parameter int unsigned RETRY1_T = 5200,
  parameter int unsigned RETRY2_T = 5000,
  parameter int unsigned CNT_W    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             pin_req,
  input  logic             bat_ok,
  input  logic             near_bat,
  input  logic             at_95,
  input  logic             bus_ovp,
  input  logic             ilim_act,
  input  logic             therm,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             precharge_en,
  output logic             switch_en,
  output logic             ilim_full,
  output logic [2:0]       fault_code,
  output logic             stat_pulse,
  output logic             boost_cmd_clr
);
  import boost_seq_pkg::*;

  seq_state_t state, state_d;
  logic [2:0] code_q, code_d, fcode;
  logic       retried, retried_d;
  logic       evt_q, fault_now, reload_self;

  function automatic logic [CNT_W-1:0] window_for(input seq_state_t s, input logic again);
    case (s)
      ST_LIN:   return CNT_W'(LIN_T);
      ST_SS1:   return CNT_W'(SS1_T);
      ST_SS2:   return CNT_W'(SS2_T);
      ST_RUN:   return CNT_W'(CL_T);
      ST_FAULT: return again ? CNT_W'(RETRY2_T) : CNT_W'(RETRY1_T);
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    state_d     = state;
    code_d      = code_q;
    retried_d   = retried;
    fault_now   = 1'b0;
    fcode       = FC_NONE;
    reload_self = 1'b0;
    if (!run_en) begin
      state_d   = ST_IDLE;
      retried_d = 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          retried_d = 1'b0;
          if (bat_ok) begin
            state_d = ST_LIN;
            code_d  = FC_NONE;
          end
        end
        ST_LIN: begin
          if (near_bat)     state_d = ST_SS1;
          else if (expired) begin fault_now = 1'b1; fcode = FC_TIMEOUT; end
        end
        ST_SS1: begin
          if (at_95)        state_d = ST_RUN;
          else if (expired) state_d = ST_SS2;
        end
        ST_SS2: begin
          if (at_95)        state_d = ST_RUN;
          else if (expired) begin fault_now = 1'b1; fcode = FC_TIMEOUT; end
        end
        ST_RUN: begin
          fcode = run_fault(therm, bus_ovp, bat_ok, expired && ilim_act);
          if (fcode != FC_NONE) fault_now   = 1'b1;
          else if (!ilim_act)   reload_self = 1'b1;
        end
        ST_FAULT: begin
          if (pin_req && expired) begin
            retried_d = 1'b1;
            if (bat_ok) state_d     = ST_LIN;
            else        reload_self = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
      if (fault_now) begin
        state_d = ST_FAULT;
        code_d  = fcode;
      end
    end
  end

  assign load     = (state_d != state) || reload_self;
  assign load_val = window_for(state_d, retried_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      code_q  <= FC_NONE;
      retried <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      state   <= state_d;
      code_q  <= code_d;
      retried <= retried_d;
      evt_q   <= fault_now;
    end
  end

  assign precharge_en  = run_en && (state == ST_LIN);
  assign switch_en     = run_en && (state == ST_SS1 || state == ST_SS2 || state == ST_RUN);
  assign ilim_full     = run_en && (state == ST_SS2 || state == ST_RUN);
  assign stat_pulse    = run_en && evt_q;
  assign boost_cmd_clr = run_en && evt_q;
  assign fault_code    = code_q;

  AST_NO_START_LOW_BAT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !bat_ok) |=> state != ST_LIN); // R1
  AST_STAGES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(precharge_en && switch_en)); // R3
  AST_FULL_WITH_SW: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_full |-> switch_en); // R5
  AST_STAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pulse |=> !stat_pulse); // R8
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT) |-> (!switch_en && !precharge_en)); // R8
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT) |=> (state != ST_FAULT || $stable(fault_code))); // R8
  AST_IDLE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> state == ST_IDLE); // R12

endmodule

// File: rtl/boost_start_seq.sv
module boost_start_seq #(
  parameter int unsigned LIN_US    = 560,
  parameter int unsigned SS1_US    = 128,
  parameter int unsigned SS2_US    = 384,
  parameter int unsigned CL_US     = 50,
  parameter int unsigned RETRY1_US = 5200,
  parameter int unsigned RETRY2_US = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_boost_en,
  input  logic       hiz_req,
  input  logic       pin_boost_allow,
  input  logic       pin_active_high,
  input  logic       otg_pin,
  input  logic       us_tick,
  input  logic       vout_near_bat,
  input  logic       vout_at_95,
  input  logic       bat_above_uv,
  input  logic       bus_ovp,
  input  logic       ilim_active,
  input  logic       therm_shdn,
  output logic       precharge_en,
  output logic       switch_en,
  output logic       ilim_full,
  output logic [2:0] fault_code,
  output logic       stat_pulse,
  output logic       boost_cmd_clr
);
  import boost_seq_pkg::*;

  localparam int unsigned MAX_T = max2(max2(max2(LIN_US, SS1_US), max2(SS2_US, CL_US)),
                                       max2(RETRY1_US, RETRY2_US));
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic             run_en, pin_req, win_load, win_expired;
  logic [CNT_W-1:0] win_val;

  boost_seq_enable u_enable (
    .host_boost_en  (host_boost_en),
    .hiz_req        (hiz_req),
    .pin_boost_allow(pin_boost_allow),
    .pin_active_high(pin_active_high),
    .otg_pin        (otg_pin),
    .run_en         (run_en),
    .pin_req        (pin_req)
  );

  boost_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (win_load),
    .load_val(win_val),
    .tick    (us_tick),
    .expired (win_expired)
  );

  boost_seq_fsm #(
    .LIN_T(LIN_US), .SS1_T(SS1_US), .SS2_T(SS2_US), .CL_T(CL_US),
    .RETRY1_T(RETRY1_US), .RETRY2_T(RETRY2_US), .CNT_W(CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .pin_req      (pin_req),
    .bat_ok       (bat_above_uv),
    .near_bat     (vout_near_bat),
    .at_95        (vout_at_95),
    .bus_ovp      (bus_ovp),
    .ilim_act     (ilim_active),
    .therm        (therm_shdn),
    .expired      (win_expired),
    .load         (win_load),
    .load_val     (win_val),
    .precharge_en (precharge_en),
    .switch_en    (switch_en),
    .ilim_full    (ilim_full),
    .fault_code   (fault_code),
    .stat_pulse   (stat_pulse),
    .boost_cmd_clr(boost_cmd_clr)
  );

  AST_PIN_BEATS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_req && hiz_req && bat_above_uv && !precharge_en && !switch_en && fault_code == 3'b000)
      |=> (precharge_en || switch_en || fault_code != 3'b000 || !pin_req)); // R11

endmodule

// File: tb/boost_start_seq_bench.sv
module boost_start_seq_bench;

  localparam int LIN = 560, SS1 = 128, SS2 = 384, CL = 50, RT1 = 5200, RT2 = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_boost_en = 0, hiz_req = 0, pin_boost_allow = 0, pin_active_high = 0, otg_pin = 1;
  logic us_tick = 1, vout_near_bat = 0, vout_at_95 = 0, bat_above_uv = 1;
  logic bus_ovp = 0, ilim_active = 0, therm_shdn = 0;
  logic precharge_en, switch_en, ilim_full, stat_pulse, boost_cmd_clr;
  logic [2:0] fault_code;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  boost_start_seq u_boost_start_seq (
    .clk(clk), .rst_n(rst_n), .host_boost_en(host_boost_en), .hiz_req(hiz_req),
    .pin_boost_allow(pin_boost_allow), .pin_active_high(pin_active_high), .otg_pin(otg_pin),
    .us_tick(us_tick), .vout_near_bat(vout_near_bat), .vout_at_95(vout_at_95),
    .bat_above_uv(bat_above_uv), .bus_ovp(bus_ovp), .ilim_active(ilim_active),
    .therm_shdn(therm_shdn), .precharge_en(precharge_en), .switch_en(switch_en),
    .ilim_full(ilim_full), .fault_code(fault_code), .stat_pulse(stat_pulse),
    .boost_cmd_clr(boost_cmd_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic bit probe(input int sel);
    case (sel)
      0: return precharge_en;
      1: return switch_en && !ilim_full;
      2: return ilim_full;
      3: return switch_en;
      default: return 1'b0;
    endcase
  endfunction

  task automatic count_while(input int sel, input bit val, output int n);
    n = 0;
    while (probe(sel) == val && n < 20000) begin
      n++;
      step();
    end
  endtask

  task automatic restart();
    host_boost_en = 0; step();
    host_boost_en = 1; step();
  endtask

  task automatic to_run();
    vout_near_bat = 1; vout_at_95 = 1;
    restart(); step(); step();
  endtask

  task automatic run_fault_case(input logic th, input logic ov, input logic low, input int exp);
    to_run();
    chk("R4 in regulation", int'(switch_en && ilim_full), 1);
    therm_shdn = th; bus_ovp = ov; bat_above_uv = !low;
    step();
    chk("R7 fault code", int'(fault_code), exp);
    therm_shdn = 0; bus_ovp = 0; bat_above_uv = 1;
  endtask

  initial begin
    int n;
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 reset precharge", int'(precharge_en), 0);
    chk("R1 reset switch", int'(switch_en), 0);
    chk("R8 reset code", int'(fault_code), 0);
    chk("R8 reset stat", int'(stat_pulse), 0);

    // R1: undervoltage blocks start
    bat_above_uv = 0; host_boost_en = 1;
    repeat (5) step();
    chk("R1 low battery no start", int'(precharge_en || switch_en), 0);
    bat_above_uv = 1; step();
    chk("R1 start precharge", int'(precharge_en), 1);

    // R2: precharge window
    count_while(0, 1, n);
    chk("R2 precharge length", n, LIN + 1);
    chk("R2 timeout code", int'(fault_code), 2);
    chk("R8 stat pulse", int'(stat_pulse), 1);
    chk("R8 cmd clear", int'(boost_cmd_clr), 1);
    chk("R8 stage off", int'(switch_en || precharge_en), 0);
    step();
    chk("R8 stat single", int'(stat_pulse), 0);
    chk("R8 clr single", int'(boost_cmd_clr), 0);

    // R10: host mode waits
    repeat (6000) step();
    chk("R10 no auto retry", int'(precharge_en), 0);
    chk("R8 code held", int'(fault_code), 2);
    restart();
    chk("R10 restart precharge", int'(precharge_en), 1);
    chk("R10 code cleared", int'(fault_code), 0);

    // R3/R5: soft-start windows
    vout_near_bat = 1; step();
    chk("R3 stage one sw", int'(switch_en), 1);
    chk("R3 stage one half", int'(ilim_full), 0);
    chk("R3 precharge off", int'(precharge_en), 0);
    count_while(1, 1, n);
    chk("R5 stage one length", n, SS1 + 1);
    chk("R5 full limit", int'(ilim_full && switch_en), 1);
    count_while(2, 1, n);
    chk("R5 stage two length", n, SS2 + 1);
    chk("R5 stage two code", int'(fault_code), 2);

    // R4: 95% reached in stage one
    restart(); step();
    repeat (10) step();
    chk("R4 still stage one", int'(switch_en && !ilim_full), 1);
    vout_at_95 = 1; step();
    chk("R4 full limit in regulation", int'(ilim_full && switch_en), 1);

    // R6: current limit persistence
    ilim_active = 1;
    repeat (CL) step();
    ilim_active = 0;
    repeat (3) step();
    chk("R6 exactly window no fault", int'(switch_en), 1);
    chk("R6 exactly window code", int'(fault_code), 0);
    ilim_active = 1;
    count_while(3, 1, n);
    chk("R6 limit run length", n, CL + 1);
    chk("R6 limit code", int'(fault_code), 2);
    ilim_active = 0;

    // R7: priority
    run_fault_case(1, 1, 1, 5);
    run_fault_case(0, 1, 1, 1);
    run_fault_case(0, 0, 1, 3);

    // R12: drop enable mid soft-start
    vout_near_bat = 1; vout_at_95 = 0;
    restart(); step();
    chk("R12 in stage one", int'(switch_en), 1);
    host_boost_en = 0; #2;
    chk("R12 same-cycle off", int'(switch_en || ilim_full || precharge_en), 0);
    step(); step();
    vout_near_bat = 0; host_boost_en = 1; step();
    chk("R12 idle then restart", int'(precharge_en), 1);

    // R13: no tick, no expiry
    us_tick = 0;
    repeat (2000) step();
    chk("R13 no expiry without tick", int'(precharge_en), 1);
    us_tick = 1;
    count_while(0, 1, n);
    chk("R13 window resumes", n, LIN + 1);

    // R11: pin control
    host_boost_en = 0; hiz_req = 1; pin_boost_allow = 1; pin_active_high = 0; otg_pin = 1;
    repeat (3) step();
    chk("R11 pin inactive level", int'(precharge_en || switch_en), 0);
    host_boost_en = 1; repeat (3) step();
    chk("R11 hiz blocks host", int'(precharge_en || switch_en), 0);
    host_boost_en = 0; step();
    otg_pin = 0; step();
    chk("R11 pin overrides hiz", int'(precharge_en), 1);

    // R9: automatic retry intervals
    count_while(0, 1, n);
    chk("R2 pin precharge length", n, LIN + 1);
    count_while(0, 0, n);
    chk("R9 first retry gap", n, RT1 + 1);
    count_while(0, 1, n);
    chk("R2 retry precharge length", n, LIN + 1);
    count_while(0, 0, n);
    chk("R9 repeat retry gap", n, RT2 + 1);
    otg_pin = 1; #2;
    chk("R12 pin release off", int'(precharge_en), 0);
    step();
    pin_boost_allow = 0; otg_pin = 0;
    repeat (3) step();
    chk("R11 allow gates pin", int'(precharge_en || switch_en), 0);
    pin_boost_allow = 1; pin_active_high = 1; otg_pin = 1; step();
    chk("R11 active-high pin", int'(precharge_en), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule